// File: doc/BRIEF.md
# Sequencer Condition Flag Evaluator

This block keeps the condition flags that a serial-bus controller's message sequencer branches on, and answers whether a conditional instruction should run. It holds eight general-purpose flags. The lowest two of these flags also hold the result of the last time compare. That compare checks an instruction parameter against the running message time count. The sequencer or a host can set, clear or toggle the general-purpose flags through a bit mask. The block also captures a summary of the most recent message when the message-done strobe arrives. The summary holds the retry count, bad message, format error, no response, masked status and good data block transfer.

To evaluate a condition, the sequencer raises `eval_req` together with a 4-bit condition code and an inverse bit. One clock later the block returns a registered `cond_true` and a one-cycle `cond_valid` pulse. The result uses the flags as they stood before that clock edge. Message decoding and instruction fetch are handled elsewhere.

Top module: `seq_cond_eval`

## Requirements
- R1: After reset, all general-purpose and message flags are 0, and `cond_valid` and `cond_true` are 0.
- R2: On `cmp_valid`, if `cmp_param < msg_time`, flag 0 (less-than) becomes 1 and flag 1 (equal) becomes 0. If they are equal, flag 0 becomes 0 and flag 1 becomes 1. If the parameter is greater, both become 0. Reading code 1 inverted therefore gives greater-or-equal, and reading code 2 inverted gives not-equal.
- R3: Code 0 with `cond_inv`=0 always evaluates true. Code 0 with `cond_inv`=1 always evaluates false, which gives a skip.
- R4: `cond_inv`=1 returns the complement of the true-sense value of every code.
- R5: A flag instruction (`flg_valid`) applies `flg_op` to the flags selected by `flg_mask`. The encodings are 0 = no change, 1 = set, 2 = clear and 3 = toggle. Flags outside the mask are unchanged.
- R6: A host write (`host_wr`) uses the same operation encoding. When a host write and a flag instruction occur in the same cycle, the host write is dropped. If `cmp_valid` and `flg_valid` occur together, the compare owns flags 0 and 1.
- R7: Flags 0 and 1 are the same storage as GP0 and GP1. A flag operation on them is seen through codes 1 and 2. Codes 3 to 8 read GP2 to GP7.
- R8: Codes 14 and 15 read bit 0 and bit 1 of the retry count latched at message done. The count is 0 for no retry, 1 for one retry and 2 for two retries.
- R9: At message done, bad message (code 13) is set to format error OR loop test fail OR no response. Format error is code 10, no response is code 9 and masked status is code 12. Masked status does not affect bad message.
- R10: At message done, good data block (code 11) becomes 1 only for an error-free message (no format error, no no-response) whose `msg_type` is 1 (RT-to-BC), 2 (RT-to-RT) or 3 (transmit mode code with data). It is 0 for type 0 (BC-to-RT), type 4 (receive mode code with data) and type 5 (mode code without data). A loop test fail does not affect it.
- R11: Message flags change only on a cycle with `msg_done`. Otherwise they hold.
- R12: `cond_valid` is high exactly in the cycle after `eval_req`. `cond_true` reflects the flags before the same clock edge, so a flag update issued in the same cycle as the request is not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_req | input | 1 | Evaluate request |
| cond_sel | input | 4 | Condition code |
| cond_inv | input | 1 | Inverse sense select |
| cond_valid | output | 1 | Result valid pulse |
| cond_true | output | 1 | Registered condition result |
| cmp_valid | input | 1 | Time compare strobe |
| cmp_param | input | TIME_W | Instruction parameter |
| msg_time | input | TIME_W | Message time count |
| flg_valid | input | 1 | Flag instruction strobe |
| flg_op | input | 2 | Flag instruction operation |
| flg_mask | input | 8 | Flag instruction mask |
| host_wr | input | 1 | Host flag write strobe |
| host_op | input | 2 | Host operation |
| host_mask | input | 8 | Host mask |
| msg_done | input | 1 | Message complete strobe |
| msg_retries | input | 2 | Retry count of the message |
| msg_fmt_err | input | 1 | Format error seen |
| msg_loop_fail | input | 1 | Loop test failed |
| msg_no_resp | input | 1 | No response |
| msg_masked_sts | input | 1 | Masked status condition |
| msg_type | input | 3 | Message type |

## Verification
The checker assumes that the sequencer never raises `cmp_valid` and `flg_valid` in the same cycle. It also assumes that `msg_type` holds a defined code from 0 to 5 whenever `msg_done` is high. The directed tasks drive one instruction strobe at a time, and they keep message types inside that range. Host writes are allowed to collide with flag instructions, because that collision has a defined outcome. All strobes are single-cycle pulses driven on the falling edge.

// File: rtl/seq_cond_pkg.sv
package seq_cond_pkg;
  localparam int GP_N     = 8;
  localparam int CSEL_W   = 4;
  localparam int CODE_N   = 1 << CSEL_W;
  localparam int RETRY_W  = 2;
  localparam int MTYPE_W  = 3;

  typedef enum logic [1:0] {
    FOP_NONE = 2'd0,
    FOP_SET  = 2'd1,
    FOP_CLR  = 2'd2,
    FOP_TGL  = 2'd3
  } flag_op_e;

  typedef enum logic [CSEL_W-1:0] {
    CC_ALWAYS   = 4'd0,
    CC_LT_GP0   = 4'd1,
    CC_EQ_GP1   = 4'd2,
    CC_GP2      = 4'd3,
    CC_GP3      = 4'd4,
    CC_GP4      = 4'd5,
    CC_GP5      = 4'd6,
    CC_GP6      = 4'd7,
    CC_GP7      = 4'd8,
    CC_NORESP   = 4'd9,
    CC_FMT_ERR  = 4'd10,
    CC_GOOD_BLK = 4'd11,
    CC_MASKED   = 4'd12,
    CC_BAD_MSG  = 4'd13,
    CC_RETRY0   = 4'd14,
    CC_RETRY1   = 4'd15
  } cond_e;

  typedef enum logic [MTYPE_W-1:0] {
    MT_BC2RT      = 3'd0,
    MT_RT2BC      = 3'd1,
    MT_RT2RT      = 3'd2,
    MT_MC_TX_DATA = 3'd3,
    MT_MC_RX_DATA = 3'd4,
    MT_MC_NODATA  = 3'd5
  } msg_type_e;

  typedef struct packed {
    logic [RETRY_W-1:0] retries;
    logic               bad;
    logic               fmt;
    logic               noresp;
    logic               masked;
    logic               good_blk;
  } msg_flags_t;

  // Per-bit result of a mask operation on one flag.
  function automatic logic flag_bit_next(input logic [1:0] op, input logic sel, input logic cur);
    logic nxt;
    nxt = cur;
    if (sel) begin
      case (flag_op_e'(op))
        FOP_SET:  nxt = 1'b1;
        FOP_CLR:  nxt = 1'b0;
        FOP_TGL:  nxt = ~cur;
        default:  nxt = cur;
      endcase
    end
    return nxt;
  endfunction
endpackage

// File: rtl/seq_gp_flags.sv
module seq_gp_flags
  import seq_cond_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [TIME_W-1:0] cmp_param,
  input  logic [TIME_W-1:0] msg_time,
  input  logic              flg_valid,
  input  logic [1:0]        flg_op,
  input  logic [GP_N-1:0]   flg_mask,
  input  logic              host_wr,
  input  logic [1:0]        host_op,
  input  logic [GP_N-1:0]   host_mask,
  output logic [GP_N-1:0]   gp_q
);
  logic [GP_N-1:0] gp_d;
  logic [1:0]      op_sel;
  logic [GP_N-1:0] mask_sel;
  logic            cmp_lt;
  logic            cmp_eq;
  logic            gp_en;

  // Instruction owns the mask port over the host in a collision.
  always_comb begin
    if (flg_valid) begin
      op_sel   = flg_op;
      mask_sel = flg_mask;
    end else if (host_wr) begin
      op_sel   = host_op;
      mask_sel = host_mask;
    end else begin
      op_sel   = FOP_NONE;
      mask_sel = '0;
    end
  end

  assign cmp_lt = (cmp_param < msg_time);
  assign cmp_eq = (cmp_param == msg_time);
  assign gp_en  = cmp_valid | flg_valid | host_wr;

  for (genvar b = 0; b < GP_N; b++) begin : g_bit
    if (b == 0) begin : g_lt
      assign gp_d[b] = cmp_valid ? cmp_lt : flag_bit_next(op_sel, mask_sel[b], gp_q[b]);
    end else if (b == 1) begin : g_eq
      assign gp_d[b] = cmp_valid ? cmp_eq : flag_bit_next(op_sel, mask_sel[b], gp_q[b]);
    end else begin : g_plain
      assign gp_d[b] = flag_bit_next(op_sel, mask_sel[b], gp_q[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_q <= '0;
    end else if (gp_en) begin
      gp_q <= gp_d;
    end
  end
endmodule

// File: rtl/seq_msg_status.sv
module seq_msg_status
  import seq_cond_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_done,
  input  logic [RETRY_W-1:0] msg_retries,
  input  logic               msg_fmt_err,
  input  logic               msg_loop_fail,
  input  logic               msg_no_resp,
  input  logic               msg_masked_sts,
  input  logic [MTYPE_W-1:0] msg_type,
  output msg_flags_t         msg_q
);
  msg_flags_t msg_d;
  logic       blk_type_ok;

  always_comb begin
    case (msg_type_e'(msg_type))
      MT_RT2BC, MT_RT2RT, MT_MC_TX_DATA: blk_type_ok = 1'b1;
      default:                           blk_type_ok = 1'b0;
    endcase
  end

  always_comb begin
    msg_d.retries  = msg_retries;
    msg_d.fmt      = msg_fmt_err;
    msg_d.noresp   = msg_no_resp;
    msg_d.masked   = msg_masked_sts;
    msg_d.bad      = msg_fmt_err | msg_loop_fail | msg_no_resp;
    msg_d.good_blk = blk_type_ok & ~msg_fmt_err & ~msg_no_resp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q <= '0;
    end else if (msg_done) begin
      msg_q <= msg_d;
    end
  end
endmodule

// File: rtl/seq_cond_mux.sv
module seq_cond_mux
  import seq_cond_pkg::*;
(
  input  logic [GP_N-1:0]   gp_q,
  input  msg_flags_t        msg_q,
  input  logic [CSEL_W-1:0] cond_sel,
  input  logic              cond_inv,
  output logic              cond_raw
);
  logic [CODE_N-1:0] flag_vec;

  assign flag_vec[CC_ALWAYS]   = 1'b1;
  assign flag_vec[CC_LT_GP0]   = gp_q[0];
  assign flag_vec[CC_EQ_GP1]   = gp_q[1];
  for (genvar g = 2; g < GP_N; g++) begin : g_gp
    assign flag_vec[int'(CC_GP2) + g - 2] = gp_q[g];
  end
  assign flag_vec[CC_NORESP]   = msg_q.noresp;
  assign flag_vec[CC_FMT_ERR]  = msg_q.fmt;
  assign flag_vec[CC_GOOD_BLK] = msg_q.good_blk;
  assign flag_vec[CC_MASKED]   = msg_q.masked;
  assign flag_vec[CC_BAD_MSG]  = msg_q.bad;
  assign flag_vec[CC_RETRY0]   = msg_q.retries[0];
  assign flag_vec[CC_RETRY1]   = msg_q.retries[1];

  assign cond_raw = flag_vec[cond_sel] ^ cond_inv;
endmodule

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
  import seq_cond_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_req,
  input  logic [3:0]        cond_sel,
  input  logic              cond_inv,
  output logic              cond_valid,
  output logic              cond_true,
  input  logic              cmp_valid,
  input  logic [TIME_W-1:0] cmp_param,
  input  logic [TIME_W-1:0] msg_time,
  input  logic              flg_valid,
  input  logic [1:0]        flg_op,
  input  logic [7:0]        flg_mask,
  input  logic              host_wr,
  input  logic [1:0]        host_op,
  input  logic [7:0]        host_mask,
  input  logic              msg_done,
  input  logic [1:0]        msg_retries,
  input  logic              msg_fmt_err,
  input  logic              msg_loop_fail,
  input  logic              msg_no_resp,
  input  logic              msg_masked_sts,
  input  logic [2:0]        msg_type
);
  logic [1:0]      rst_pipe;
  logic            rst_sync_n;
  logic [GP_N-1:0] gp_q;
  msg_flags_t      msg_q;
  logic            cond_raw;
  logic            cond_true_d;
  logic            cond_valid_d;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  seq_gp_flags #(.TIME_W(TIME_W)) u_gp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmp_valid (cmp_valid),
    .cmp_param (cmp_param),
    .msg_time  (msg_time),
    .flg_valid (flg_valid),
    .flg_op    (flg_op),
    .flg_mask  (flg_mask),
    .host_wr   (host_wr),
    .host_op   (host_op),
    .host_mask (host_mask),
    .gp_q      (gp_q)
  );

  seq_msg_status u_msg (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .msg_done       (msg_done),
    .msg_retries    (msg_retries),
    .msg_fmt_err    (msg_fmt_err),
    .msg_loop_fail  (msg_loop_fail),
    .msg_no_resp    (msg_no_resp),
    .msg_masked_sts (msg_masked_sts),
    .msg_type       (msg_type),
    .msg_q          (msg_q)
  );

  seq_cond_mux u_mux (
    .gp_q     (gp_q),
    .msg_q    (msg_q),
    .cond_sel (cond_sel),
    .cond_inv (cond_inv),
    .cond_raw (cond_raw)
  );

  always_comb begin
    cond_valid_d = eval_req;
    cond_true_d  = eval_req ? cond_raw : cond_true;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cond_valid <= 1'b0;
      cond_true  <= 1'b0;
    end else begin
      cond_valid <= cond_valid_d;
      cond_true  <= cond_true_d;
    end
  end
endmodule

// File: rtl/seq_cond_eval_chk.sv
module seq_cond_eval_chk
  import seq_cond_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eval_req,
  input logic [3:0]        cond_sel,
  input logic              cond_inv,
  input logic              cond_valid,
  input logic              cond_true,
  input logic              cmp_valid,
  input logic [TIME_W-1:0] cmp_param,
  input logic [TIME_W-1:0] msg_time,
  input logic              flg_valid,
  input logic              host_wr,
  input logic              msg_done,
  input logic [2:0]        msg_type,
  input logic              msg_fmt_err,
  input logic              msg_no_resp,
  input logic              msg_loop_fail,
  input logic [GP_N-1:0]   gp_q,
  input msg_flags_t        msg_q
);
  p_valid_after_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    eval_req |=> cond_valid);
  p_valid_only_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_req |=> !cond_valid);
  p_always_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && cond_sel == 4'd0 && !cond_inv) |=> cond_true);
  p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_req && cond_sel == 4'd0 && cond_inv) |=> !cond_true);
  p_cmp_less_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_param < msg_time) |=> (gp_q[0] && !gp_q[1]));
  p_cmp_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_param == msg_time) |=> (!gp_q[0] && gp_q[1]));
  p_gp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !flg_valid && !host_wr) |=> $stable(gp_q));
  p_msg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_done |=> $stable(msg_q));
  p_bad_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && (msg_fmt_err || msg_no_resp || msg_loop_fail)) |=> msg_q.bad);
  p_blk_bc2rt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && msg_type == 3'd0) |=> !msg_q.good_blk);
  // Input assumptions (R6, R10): one instruction strobe per cycle, legal type.
  p_one_instr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_valid && flg_valid));
  p_type_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> (msg_type <= 3'd5));
endmodule

bind seq_cond_eval seq_cond_eval_chk #(.TIME_W(TIME_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .eval_req      (eval_req),
  .cond_sel      (cond_sel),
  .cond_inv      (cond_inv),
  .cond_valid    (cond_valid),
  .cond_true     (cond_true),
  .cmp_valid     (cmp_valid),
  .cmp_param     (cmp_param),
  .msg_time      (msg_time),
  .flg_valid     (flg_valid),
  .host_wr       (host_wr),
  .msg_done      (msg_done),
  .msg_type      (msg_type),
  .msg_fmt_err   (msg_fmt_err),
  .msg_no_resp   (msg_no_resp),
  .msg_loop_fail (msg_loop_fail),
  .gp_q          (gp_q),
  .msg_q         (msg_q)
);

// File: tb/test_seq_cond_eval.sv
`timescale 1ns/1ps
module test_seq_cond_eval;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          eval_req;
  logic [3:0]    cond_sel;
  logic          cond_inv;
  logic          cond_valid;
  logic          cond_true;
  logic          cmp_valid;
  logic [TW-1:0] cmp_param;
  logic [TW-1:0] msg_time;
  logic          flg_valid;
  logic [1:0]    flg_op;
  logic [7:0]    flg_mask;
  logic          host_wr;
  logic [1:0]    host_op;
  logic [7:0]    host_mask;
  logic          msg_done;
  logic [1:0]    msg_retries;
  logic          msg_fmt_err;
  logic          msg_loop_fail;
  logic          msg_no_resp;
  logic          msg_masked_sts;
  logic [2:0]    msg_type;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seq_cond_eval #(.TIME_W(TW)) i_seq_cond_eval (.*);

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic eval(input string tag, input logic [3:0] sel, input logic inv, input logic exp);
    @(negedge clk);
    eval_req = 1'b1; cond_sel = sel; cond_inv = inv;
    @(negedge clk);
    eval_req = 1'b0;
    check({tag, " valid"}, cond_valid, 1'b1);
    check(tag, cond_true, exp);
  endtask

  task automatic flag_instr(input logic [1:0] op, input logic [7:0] mask);
    @(negedge clk);
    flg_valid = 1'b1; flg_op = op; flg_mask = mask;
    @(negedge clk);
    flg_valid = 1'b0;
  endtask

  task automatic host_write(input logic [1:0] op, input logic [7:0] mask);
    @(negedge clk);
    host_wr = 1'b1; host_op = op; host_mask = mask;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic compare(input logic [TW-1:0] p, input logic [TW-1:0] t);
    @(negedge clk);
    cmp_valid = 1'b1; cmp_param = p; msg_time = t;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic message(input logic [1:0] rt, input logic fe, input logic lf,
                         input logic nr, input logic ms, input logic [2:0] ty);
    @(negedge clk);
    msg_done = 1'b1; msg_retries = rt; msg_fmt_err = fe; msg_loop_fail = lf;
    msg_no_resp = nr; msg_masked_sts = ms; msg_type = ty;
    @(negedge clk);
    msg_done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid after reset", cond_valid, 1'b0);
    check("R1 result after reset", cond_true, 1'b0);
    for (int c = 1; c < 16; c++) eval("R1 flag clear", 4'(c), 1'b0, 1'b0);
  endtask

  task automatic t_always_never();
    eval("R3 always", 4'd0, 1'b0, 1'b1);
    eval("R3 never", 4'd0, 1'b1, 1'b0);
    @(negedge clk);
    check("R12 no valid without request", cond_valid, 1'b0);
  endtask

  task automatic t_compare();
    compare(16'd50, 16'd100);
    eval("R2 less lt", 4'd1, 1'b0, 1'b1);
    eval("R2 less ne", 4'd2, 1'b1, 1'b1);
    eval("R2 less eq", 4'd2, 1'b0, 1'b0);
    eval("R4 less ge", 4'd1, 1'b1, 1'b0);
    compare(16'd100, 16'd100);
    eval("R2 equal ge", 4'd1, 1'b1, 1'b1);
    eval("R2 equal eq", 4'd2, 1'b0, 1'b1);
    compare(16'd200, 16'd100);
    eval("R2 greater ge", 4'd1, 1'b1, 1'b1);
    eval("R2 greater ne", 4'd2, 1'b1, 1'b1);
    eval("R2 greater lt", 4'd1, 1'b0, 1'b0);
  endtask

  task automatic t_flag_ops();
    flag_instr(2'd2, 8'hFF);
    flag_instr(2'd1, 8'hFC);
    for (int g = 2; g < 8; g++) eval("R7 gp set", 4'(g + 1), 1'b0, 1'b1);
    eval("R5 mask excludes gp0", 4'd1, 1'b0, 1'b0);
    flag_instr(2'd3, 8'h28);
    eval("R5 toggle gp3", 4'd4, 1'b0, 1'b0);
    eval("R5 toggle gp5", 4'd6, 1'b0, 1'b0);
    eval("R5 untoggled gp4", 4'd5, 1'b0, 1'b1);
    flag_instr(2'd0, 8'hFF);
    eval("R5 op none gp4", 4'd5, 1'b0, 1'b1);
    eval("R5 op none gp3", 4'd4, 1'b0, 1'b0);
    flag_instr(2'd2, 8'hFF);
    eval("R5 clear gp7", 4'd8, 1'b0, 1'b0);
    eval("R4 clear gp7 inverse", 4'd8, 1'b1, 1'b1);
    flag_instr(2'd1, 8'h03);
    eval("R7 gp0 via lt", 4'd1, 1'b0, 1'b1);
    eval("R7 gp1 via eq", 4'd2, 1'b0, 1'b1);
    flag_instr(2'd2, 8'h03);
  endtask

  task automatic t_host();
    host_write(2'd1, 8'h10);
    eval("R6 host set gp4", 4'd5, 1'b0, 1'b1);
    host_write(2'd3, 8'h10);
    eval("R6 host toggle gp4", 4'd5, 1'b0, 1'b0);
    @(negedge clk);
    flg_valid = 1'b1; flg_op = 2'd1; flg_mask = 8'h04;
    host_wr = 1'b1; host_op = 2'd1; host_mask = 8'h80;
    @(negedge clk);
    flg_valid = 1'b0; host_wr = 1'b0;
    eval("R6 instr wins gp2", 4'd3, 1'b0, 1'b1);
    eval("R6 host dropped gp7", 4'd8, 1'b0, 1'b0);
    flag_instr(2'd2, 8'hFF);
  endtask

  task automatic t_messages();
    message(2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1);
    eval("R8 two retries bit1", 4'd15, 1'b0, 1'b1);
    eval("R8 two retries bit0", 4'd14, 1'b0, 1'b0);
    eval("R10 rt2bc clean", 4'd11, 1'b0, 1'b1);
    eval("R9 clean good", 4'd13, 1'b1, 1'b1);
    message(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1);
    eval("R8 one retry", 4'd14, 1'b0, 1'b1);
    eval("R9 fmt bad", 4'd13, 1'b0, 1'b1);
    eval("R9 fmt flag", 4'd10, 1'b0, 1'b1);
    eval("R10 fmt blocks blk", 4'd11, 1'b0, 1'b0);
    message(2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2);
    eval("R9 masked set", 4'd12, 1'b0, 1'b1);
    eval("R9 masked not bad", 4'd13, 1'b0, 1'b0);
    eval("R10 rt2rt blk", 4'd11, 1'b0, 1'b1);
    eval("R8 no retry", 4'd15, 1'b0, 1'b0);
    message(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd1);
    eval("R9 loop bad", 4'd13, 1'b0, 1'b1);
    eval("R10 loop ignored", 4'd11, 1'b0, 1'b1);
    message(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0);
    eval("R10 bc2rt blk", 4'd11, 1'b0, 1'b0);
    message(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3);
    eval("R10 mc tx blk", 4'd11, 1'b0, 1'b1);
    message(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4);
    eval("R10 mc rx blk", 4'd11, 1'b0, 1'b0);
    message(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5);
    eval("R10 mc nodata blk", 4'd11, 1'b0, 1'b0);
    message(2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2);
    eval("R9 noresp flag", 4'd9, 1'b0, 1'b1);
    eval("R9 noresp bad", 4'd13, 1'b0, 1'b1);
    eval("R10 noresp blk", 4'd11, 1'b0, 1'b0);
  endtask

  task automatic t_hold();
    @(negedge clk);
    msg_retries = 2'd3; msg_fmt_err = 1'b1; msg_masked_sts = 1'b1;
    msg_no_resp = 1'b0; msg_type = 3'd1;
    repeat (3) @(negedge clk);
    eval("R11 hold noresp", 4'd9, 1'b0, 1'b1);
    eval("R11 hold fmt", 4'd10, 1'b0, 1'b0);
    eval("R11 hold masked", 4'd12, 1'b0, 1'b0);
    eval("R11 hold retry", 4'd14, 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    eval_req = 1'b1; cond_sel = 4'd3; cond_inv = 1'b0;
    flg_valid = 1'b1; flg_op = 2'd1; flg_mask = 8'h04;
    @(negedge clk);
    eval_req = 1'b0; flg_valid = 1'b0;
    check("R12 old flags seen", cond_true, 1'b0);
    eval("R12 new flags seen", 4'd3, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R12 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; eval_req = 1'b0; cond_sel = '0; cond_inv = 1'b0;
    cmp_valid = 1'b0; cmp_param = '0; msg_time = '0;
    flg_valid = 1'b0; flg_op = '0; flg_mask = '0;
    host_wr = 1'b0; host_op = '0; host_mask = '0;
    msg_done = 1'b0; msg_retries = '0; msg_fmt_err = 1'b0; msg_loop_fail = 1'b0;
    msg_no_resp = 1'b0; msg_masked_sts = 1'b0; msg_type = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_always_never();
    t_compare();
    t_flag_ops();
    t_host();
    t_messages();
    t_hold();
    t_same_cycle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule